// File: doc/BRIEF.md
# Prioritized GPIO Interrupt Controller

This block collects interrupt events from up to 128 sources, either external pins or internal on-chip lines, arranged as banks of 32. Every source has its own configuration word. The word selects one of several trigger modes, sets a two-bit priority and enables idle wake-up. Each source input is synchronised and then checked for edges or levels. The result is held in a per-source pending bit, which is qualified by a per-source enable.

Four request lines go to the CPU, one for each priority level. A read-only encoder word names the single source that software should service next. Enables are changed through separate set and clear words. Pending edge events are acknowledged by writing ones. The block also holds a per-pin device-select word and a DMA trigger selector that routes two chosen pins to DMA trigger outputs. Software reaches all of this over a simple word-addressed register port, with combinational read data.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, all enables, pending bits, configuration words, device selects and DMA fields read as zero. `irq_o` and `wake_o` are low, and the encoder word reads 0xFFFFFFFF.
- R2: A source in level-high mode (mode 1) or level-low mode (mode 2) has a pending bit that follows the synchronised input, three clock edges after the pin changes. An acknowledge does not clear the bit while the level is still active.
- R3: Rising mode (3), falling mode (4) and both-edge mode (5) set the pending bit on the matching synchronised edge. The bit stays set until a one is written to it at pending word 0x000+4*bank. Zero bits in that write leave pending bits unchanged.
- R4: Modes 0, 6 and 7 never set a pending bit, whatever the pin does.
- R5: A write to 0x010+4*bank sets the enable bits that are one in the data. A write to 0x020+4*bank clears them. Zero bits leave enables as they were. Both addresses read back the current enables.
- R6: `irq_o[l]` is high exactly when some source is both pending and enabled and has priority l.
- R7: The encoder word at 0x040 returns the index of the pending, enabled source with the lowest priority value, with ties going to the lowest index. It returns 0xFFFFFFFF when no such source exists.
- R8: The configuration word of source i sits at 0x400+4*i. It holds the mode in bits [2:0], the priority in bits [5:4] and idle-wake in bit 6. Other bits read as zero.
- R9: A write to 0x030+4*bank sets the device-select bits given as ones and never clears any. The word reads back and drives `dev_sel_o`.
- R10: The DMA word at 0x044 holds pin numbers for trigger 0 in bits [6:0] and for trigger 1 in bits [14:8]. Each `dma_trig_o[k]` carries the synchronised level of the chosen pin.
- R11: `wake_o` is high while any pending source has its idle-wake bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| pin_i | input | NUM_SRC | Raw source inputs |
| irq_o | output | 4 | Request per priority level, bit 0 most urgent |
| dev_sel_o | output | NUM_SRC | Pins handed to their peripheral function |
| wake_o | output | 1 | Idle-wake request |
| dma_trig_o | output | 2 | Selected pin levels for the two DMA triggers |

## Verification
The bench targets the difference between level and edge sources after an acknowledge. A level source must come back at once while its input stays active. An edge source must stay cleared, and a zero-bit acknowledge must leave it set. A design that latched levels, or that cleared on any pending write, would give the wrong pending word. Encoder ties are tested with two sources of equal priority pending together, and then with a more urgent source added. A design that ranked by index alone, or broke ties toward the higher index, would name the wrong source. Modes 0 and 7 are toggled on an enabled pin to catch a decoder that treats unused mode codes as a trigger.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
  localparam logic [2:0] TRIG_OFF  = 3'd0;
  localparam logic [2:0] TRIG_HIGH = 3'd1;
  localparam logic [2:0] TRIG_LOW  = 3'd2;
  localparam logic [2:0] TRIG_RISE = 3'd3;
  localparam logic [2:0] TRIG_FALL = 3'd4;
  localparam logic [2:0] TRIG_BOTH = 3'd5;

  // word offsets (byte address >> 2)
  localparam int W_PEND  = 0;
  localparam int W_ENSET = 4;
  localparam int W_ENCLR = 8;
  localparam int W_DEV   = 12;
  localparam int W_ENC   = 16;
  localparam int W_DMA   = 17;
  localparam int W_CFG   = 256;

  typedef struct packed {
    logic       wake;
    logic [1:0] prio;
    logic [2:0] mode;
  } src_cfg_t;
endpackage

// File: rtl/gpic_src_cell.sv
module gpic_src_cell
  import gpic_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pin_i,
  input  logic     cfg_we_i,
  input  src_cfg_t cfg_wdata_i,
  input  logic     ack_i,
  output src_cfg_t cfg_o,
  output logic     level_o,
  output logic     pend_o
);
  logic     s1_q, s2_q, s3_q;
  logic     pend_q, pend_d;
  logic     rise, fall, hold;
  src_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      cfg_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= pend_d;
      if (cfg_we_i) cfg_q <= cfg_wdata_i;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;
  // a new edge wins over an acknowledge in the same cycle
  assign hold = pend_q & ~ack_i;

  always_comb begin
    case (cfg_q.mode)
      TRIG_HIGH: pend_d = s2_q;
      TRIG_LOW:  pend_d = ~s2_q;
      TRIG_RISE: pend_d = rise | hold;
      TRIG_FALL: pend_d = fall | hold;
      TRIG_BOTH: pend_d = rise | fall | hold;
      default:   pend_d = 1'b0;
    endcase
  end

  assign cfg_o   = cfg_q;
  assign level_o = s2_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/gpic_prio_enc.sv
module gpic_prio_enc #(
  parameter int N     = 128,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     act_i,
  input  logic [2*N-1:0]   prio_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             found;
  logic [1:0]       best;
  logic [IDX_W-1:0] idx;

  // strict compare keeps the lowest index among equal priorities
  always_comb begin
    found = 1'b0;
    best  = 2'd3;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (act_i[i] && (!found || prio_i[2*i +: 2] < best)) begin
        found = 1'b1;
        best  = prio_i[2*i +: 2];
        idx   = IDX_W'(i);
      end
    end
  end

  assign valid_o = found;
  assign idx_o   = idx;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpic_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int ADDR_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] pin_i,
  output logic [3:0]         irq_o,
  output logic [NUM_SRC-1:0] dev_sel_o,
  output logic               wake_o,
  output logic [1:0]         dma_trig_o
);
  localparam int NBANK  = NUM_SRC / 32;
  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]  word;
  logic               wr;
  logic [NUM_SRC-1:0] en_q, dev_q, pend, lvl, ack, act, wake_vec, cfg_we;
  logic [2*NUM_SRC-1:0] prio_vec;
  src_cfg_t           cfg [NUM_SRC];
  src_cfg_t           cfg_wdata;
  logic [6:0]         dma_q [2];
  logic               enc_valid;
  logic [IDX_W-1:0]   enc_idx;
  logic [3:0]         irq_d;
  logic [1:0]         trig_d;

  assign word      = addr_i[ADDR_W-1:2];
  assign wr        = req_i & we_i;
  assign cfg_wdata = '{wake: wdata_i[6], prio: wdata_i[5:4], mode: wdata_i[2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      dev_q    <= '0;
      dma_q[0] <= '0;
      dma_q[1] <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (wr && word == WORD_W'(W_ENSET + b)) en_q[b*32 +: 32] <= en_q[b*32 +: 32] | wdata_i;
        if (wr && word == WORD_W'(W_ENCLR + b)) en_q[b*32 +: 32] <= en_q[b*32 +: 32] & ~wdata_i;
        if (wr && word == WORD_W'(W_DEV + b))   dev_q[b*32 +: 32] <= dev_q[b*32 +: 32] | wdata_i;
      end
      if (wr && word == WORD_W'(W_DMA)) begin
        dma_q[0] <= wdata_i[6:0];
        dma_q[1] <= wdata_i[14:8];
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      ack[b*32 +: 32] = (wr && word == WORD_W'(W_PEND + b)) ? wdata_i : 32'h0;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign cfg_we[i] = wr && word == WORD_W'(W_CFG + i);
    gpic_src_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pin_i[i]),
      .cfg_we_i   (cfg_we[i]),
      .cfg_wdata_i(cfg_wdata),
      .ack_i      (ack[i]),
      .cfg_o      (cfg[i]),
      .level_o    (lvl[i]),
      .pend_o     (pend[i])
    );
    assign prio_vec[2*i +: 2] = cfg[i].prio;
    assign wake_vec[i]        = cfg[i].wake;
  end

  assign act = pend & en_q;

  gpic_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .act_i  (act),
    .prio_i (prio_vec),
    .valid_o(enc_valid),
    .idx_o  (enc_idx)
  );

  always_comb begin
    irq_d = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (act[i]) irq_d[prio_vec[2*i +: 2]] = 1'b1;
  end
  assign irq_o = irq_d;

  always_comb begin
    trig_d = '0;
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < NUM_SRC; i++)
        if (dma_q[k] == 7'(i)) trig_d[k] = lvl[i];
  end
  assign dma_trig_o = trig_d;

  assign wake_o    = |(pend & wake_vec);
  assign dev_sel_o = dev_q;

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (word == WORD_W'(W_PEND + b))  rdata_o = pend[b*32 +: 32];
      if (word == WORD_W'(W_ENSET + b)) rdata_o = en_q[b*32 +: 32];
      if (word == WORD_W'(W_ENCLR + b)) rdata_o = en_q[b*32 +: 32];
      if (word == WORD_W'(W_DEV + b))   rdata_o = dev_q[b*32 +: 32];
    end
    if (word == WORD_W'(W_ENC)) rdata_o = enc_valid ? 32'(enc_idx) : 32'hFFFF_FFFF;
    if (word == WORD_W'(W_DMA)) rdata_o = {17'h0, dma_q[1], 1'b0, dma_q[0]};
    for (int i = 0; i < NUM_SRC; i++)
      if (word == WORD_W'(W_CFG + i))
        rdata_o = {25'h0, cfg[i].wake, cfg[i].prio, 1'b0, cfg[i].mode};
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NUM_SRC = 128,
  parameter int ADDR_W  = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic [3:0]         irq_o,
  input logic               wake_o,
  input logic [NUM_SRC-1:0] dev_sel_o,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] pend,
  input logic               enc_valid
);
  localparam int NBANK = NUM_SRC / 32;

  logic        set_q, clr_q;
  int unsigned bank_q;
  logic [31:0] data_q;
  logic        bank_ok;

  assign bank_ok = 32'(addr_i[3:2]) < NBANK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
      bank_q <= 0;
      data_q <= '0;
    end else begin
      set_q  <= req_i && we_i && bank_ok && addr_i[ADDR_W-1:4] == (ADDR_W-4)'(1);
      clr_q  <= req_i && we_i && bank_ok && addr_i[ADDR_W-1:4] == (ADDR_W-4)'(2);
      bank_q <= 32'(addr_i[3:2]);
      data_q <= wdata_i;
    end
  end

  AST_EN_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_q |-> ((en_q[bank_q*32 +: 32] & data_q) == data_q)); // R5
  AST_EN_CLR_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> ((en_q[bank_q*32 +: 32] & data_q) == 32'h0)); // R5
  AST_NO_IRQ_WITHOUT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> (irq_o == 4'h0)); // R6
  AST_ENC_TRACKS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != 4'h0) == enc_valid); // R7
  AST_WAKE_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> !wake_o); // R11
  AST_DEV_NEVER_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(dev_sel_o) & ~dev_sel_o) == '0)); // R9
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .wake_o   (wake_o),
  .dev_sel_o(dev_sel_o),
  .en_q     (en_q),
  .pend     (pend),
  .enc_valid(enc_valid)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int NUM_SRC = 128;
  localparam int ADDR_W  = 12;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [31:0]        wdata = '0, rdata;
  logic [NUM_SRC-1:0] pin = '0;
  logic [3:0]         irq;
  logic [NUM_SRC-1:0] dev_sel;
  logic               wake;
  logic [1:0]         dma_trig;
  int                 n_run = 0, n_fail = 0;
  logic [31:0]        rv;

  always #2ns clk = ~clk;

  gpio_irq_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .irq_o(irq),
    .dev_sel_o(dev_sel), .wake_o(wake), .dma_trig_o(dma_trig)
  );

  // {write, addr, wdata, expected read}
  localparam int NV = 16;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h414, 32'h0000_0053, 32'h0},          // R8 src5 rise prio1 wake
    {1'b0, 12'h414, 32'h0,         32'h0000_0053},
    {1'b1, 12'h5FC, 32'hFFFF_FFFF, 32'h0},          // R8 src127 mode 7
    {1'b0, 12'h5FC, 32'h0,         32'h0000_0077},
    {1'b1, 12'h010, 32'h0000_00F0, 32'h0},          // R5
    {1'b1, 12'h010, 32'h0000_0003, 32'h0},
    {1'b0, 12'h010, 32'h0,         32'h0000_00F3},
    {1'b1, 12'h020, 32'h0000_0011, 32'h0},
    {1'b0, 12'h020, 32'h0,         32'h0000_00E2},
    {1'b1, 12'h01C, 32'h8000_0000, 32'h0},
    {1'b0, 12'h01C, 32'h0,         32'h8000_0000},
    {1'b1, 12'h034, 32'h0000_0005, 32'h0},          // R9
    {1'b1, 12'h034, 32'h0000_0002, 32'h0},
    {1'b0, 12'h034, 32'h0,         32'h0000_0007},
    {1'b1, 12'h044, 32'hFFFF_FF85, 32'h0},          // R10
    {1'b0, 12'h044, 32'h0,         32'h0000_7F05}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b0; we = 1'b0; addr = a;
    #1ns d = rdata;
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pin[idx] = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(4ns * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 wake", 32'(wake), 32'h0);
    rd(12'h040, rv); check("R1 encoder", rv, 32'hFFFF_FFFF);
    rd(12'h000, rv); check("R1 pending", rv, 32'h0);
    rd(12'h010, rv); check("R1 enable", rv, 32'h0);
    rd(12'h400, rv); check("R1 config", rv, 32'h0);
    rd(12'h044, rv); check("R1 dma", rv, 32'h0);
    rd(12'h030, rv); check("R1 devsel", rv, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][76]) wr(VEC[v][75:64], VEC[v][63:32]);
      else begin
        rd(VEC[v][75:64], rv);
        check($sformatf("R5/R8/R9/R10 vector %0d", v), rv, VEC[v][31:0]);
      end
    end
    check("R9 dev_sel_o", dev_sel[63:32], 32'h7);

    // R3 rising on src5 (prio1, wake, enabled)
    set_pin(5, 1'b1); settle();
    rd(12'h000, rv); check("R3 rise pend", rv, 32'h20);
    check("R6 irq level1", 32'(irq), 32'h2);
    check("R11 wake", 32'(wake), 32'h1);
    check("R10 dma trig pin5", 32'(dma_trig), 32'h1);
    rd(12'h040, rv); check("R7 encoder single", rv, 32'd5);
    set_pin(5, 1'b0); settle();
    rd(12'h000, rv); check("R3 held after fall", rv, 32'h20);
    wr(12'h000, 32'h0);
    rd(12'h000, rv); check("R3 zero ack no effect", rv, 32'h20);
    wr(12'h000, 32'h20);
    rd(12'h000, rv); check("R3 ack clears", rv, 32'h0);
    check("R6 irq after ack", 32'(irq), 32'h0);
    check("R11 wake after ack", 32'(wake), 32'h0);
    rd(12'h040, rv); check("R7 encoder empty", rv, 32'hFFFF_FFFF);

    // R3 falling on src6 (prio2)
    wr(12'h418, 32'h24);
    set_pin(6, 1'b1); settle();
    rd(12'h000, rv); check("R3 fall ignores rise", rv, 32'h0);
    set_pin(6, 1'b0); settle();
    rd(12'h000, rv); check("R3 fall pend", rv, 32'h40);
    check("R6 irq level2", 32'(irq), 32'h4);
    wr(12'h000, 32'h40);

    // R3 both edges on src7 (prio0)
    wr(12'h41C, 32'h05);
    set_pin(7, 1'b1); settle();
    rd(12'h000, rv); check("R3 both rise", rv, 32'h80);
    check("R6 irq level0", 32'(irq), 32'h1);
    wr(12'h000, 32'h80);
    set_pin(7, 1'b0); settle();
    rd(12'h000, rv); check("R3 both fall", rv, 32'h80);
    wr(12'h000, 32'h80);

    // R2 level high on src1 (prio3)
    wr(12'h404, 32'h31);
    set_pin(1, 1'b1); settle();
    rd(12'h000, rv); check("R2 level high pend", rv, 32'h2);
    check("R6 irq level3", 32'(irq), 32'h8);
    wr(12'h000, 32'h2);
    rd(12'h000, rv); check("R2 level reasserts", rv, 32'h2);
    set_pin(1, 1'b0); settle();
    rd(12'h000, rv); check("R2 level high drops", rv, 32'h0);

    // R2 level low on src40 (prio1), not enabled yet
    wr(12'h4A0, 32'h12); settle();
    rd(12'h004, rv); check("R2 level low pend", rv, 32'h100);
    check("R6 disabled no irq", 32'(irq), 32'h0);
    wr(12'h014, 32'h100);
    @(negedge clk);
    check("R6 enabled irq", 32'(irq), 32'h2);
    set_pin(40, 1'b1); settle();
    rd(12'h004, rv); check("R2 level low drops", rv, 32'h0);

    // R7 ties and priority order
    wr(12'h408, 32'h23);
    wr(12'h424, 32'h23);
    wr(12'h010, 32'h204);
    @(negedge clk); pin[2] = 1'b1; pin[9] = 1'b1; settle();
    rd(12'h040, rv); check("R7 tie lowest index", rv, 32'd2);
    set_pin(7, 1'b1); settle();
    rd(12'h040, rv); check("R7 urgent wins", rv, 32'd7);
    check("R6 two levels", 32'(irq), 32'h5);
    wr(12'h000, 32'h80);
    rd(12'h040, rv); check("R7 back to tie", rv, 32'd2);
    wr(12'h000, 32'h4);
    rd(12'h040, rv); check("R7 next index", rv, 32'd9);
    wr(12'h000, 32'h200);
    rd(12'h040, rv); check("R7 none left", rv, 32'hFFFF_FFFF);

    // R4 off modes on src0 (mode 0) and src127 (mode 7, enabled)
    @(negedge clk); pin[0] = 1'b1; pin[127] = 1'b1; settle();
    rd(12'h00C, rv); check("R4 mode7 no pend", rv, 32'h0);
    rd(12'h000, rv); check("R4 mode0 no pend", rv, 32'h0);
    check("R4 no irq", 32'(irq), 32'h0);
    check("R10 dma trig pin127", 32'(dma_trig), 32'h2);

    finish_run();
  end
endmodule